// File: doc/BRIEF.md
# Event Counter Bank

The block gives an interconnect link a set of memory-mapped performance counters. It has eight 64-bit counters. Each counter watches one of five per-cycle strobes: receive request, receive data, transmit request, transmit data, or a free-running tick. A counter picks its strobe through an 8-bit code. The strobes arrive already qualified, so any filtering happens upstream of the block. Two enables gate every increment: a global run bit and a per-counter enable bit.

Software reaches the block through a simple register port. Accesses are normally 32 bits wide, but a counter can also be read or written as one 64-bit word. When a counter rolls over from all ones to zero, it sets a sticky status bit. A status bit that is not masked raises the interrupt line. Software clears status bits by writing ones to a separate clear register.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, all counters, the run bit, the enable bits, the select codes and the status bits read as zero, every mask bit reads as one, and irq_o is low.
- R2: While the run bit (bit 0 at 0x1c00) is set and enable bit n (at 0x1c14) is set, counter n adds one on every clock edge at which its selected strobe is high. The codes are 0x30 receive request, 0x31 receive data, 0x34 transmit request, 0x35 transmit data and 0x09 tick.
- R3: While the run bit is clear, no counter changes. While enable bit n is clear, counter n holds its value.
- R4: Select register 0x1c18 holds the codes of counters 0 to 3, and 0x1c1c holds those of counters 4 to 7. Counter 4k+b uses bits 8b+7:8b of its register. Both registers read back what was written.
- R5: When counter n steps from all ones to zero, status bit n (read at 0x0818) is set at that same clock edge.
- R6: Counter n sits at 0x1d00+8n. A 64-bit access (wide_i=1) reads or writes the whole value. A 32-bit access reads or writes the low half at +0 and the high half at +4. A write to a counter wins over an increment in the same cycle.
- R7: irq_o is the OR over n of status bit n AND NOT mask bit n. The mask register is at 0x0814, and a mask bit of 1 blocks that counter's interrupt.
- R8: Writing 1 to bit n at 0x081c clears status bit n, and zero bits leave their status bits unchanged. The clear register reads as zero. If a wrap and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: A counter whose code is not in the R2 list never increments.
- R10: The register at 0x1cf0 reads the VERSION parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 64-bit counter access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | CNT_W | Write data; bits 31:0 carry 32-bit writes |
| rdata_o | output | CNT_W | Read data, combinational during a read, zero otherwise |
| rx_req_i | input | 1 | Receive request strobe |
| rx_dat_i | input | 1 | Receive data strobe |
| tx_req_i | input | 1 | Transmit request strobe |
| tx_dat_i | input | 1 | Transmit data strobe |
| tick_i | input | 1 | Cycle tick strobe |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The five strobes are driven in three patterns: all low, independent random bits every cycle, and all high. Under random strobes the counters that share a code must agree, while counters with different codes drift apart, which shows whether selection is wired per counter. Under all-high strobes every selected counter steps in lockstep, so the gating by the run bit and by each enable stands out clearly. A counter is preloaded near all ones to force wraps, and one wrap is timed to land in the same cycle as a clear write, which separates the set-wins rule from clear-wins.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

  typedef enum logic [7:0] {
    EC_TICK   = 8'h09,
    EC_RX_REQ = 8'h30,
    EC_RX_DAT = 8'h31,
    EC_TX_REQ = 8'h34,
    EC_TX_DAT = 8'h35
  } ev_code_e;

  typedef struct packed {
    logic tick;
    logic tx_dat;
    logic tx_req;
    logic rx_dat;
    logic rx_req;
  } ev_vec_t;

  localparam logic [31:0] MASK_ADDR = 32'h0000_0814;
  localparam logic [31:0] STAT_ADDR = 32'h0000_0818;
  localparam logic [31:0] CLR_ADDR  = 32'h0000_081c;
  localparam logic [31:0] RUN_ADDR  = 32'h0000_1c00;
  localparam logic [31:0] EN_ADDR   = 32'h0000_1c14;
  localparam logic [31:0] SEL_BASE  = 32'h0000_1c18;
  localparam logic [31:0] VER_ADDR  = 32'h0000_1cf0;
  localparam logic [31:0] CNT_BASE  = 32'h0000_1d00;

endpackage

// File: rtl/evt_ctr_sel.sv
module evt_ctr_sel
  import evt_ctr_pkg::*;
(
  input  logic [7:0] code_i,
  input  ev_vec_t    ev_i,
  output logic       hit_o
);

  always_comb begin
    case (code_i)
      EC_TICK:   hit_o = ev_i.tick;
      EC_RX_REQ: hit_o = ev_i.rx_req;
      EC_RX_DAT: hit_o = ev_i.rx_dat;
      EC_TX_REQ: hit_o = ev_i.tx_req;
      EC_TX_DAT: hit_o = ev_i.tx_dat;
      default:   hit_o = 1'b0;  // unsupported code never counts
    endcase
  end

endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             sw_wr;

  assign sw_wr  = wr_lo_i | wr_hi_i;
  assign wrap_o = inc_i & ~sw_wr & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo_i) cnt_q[HALF-1:0]     <= wdata_i[HALF-1:0];
      if (wr_hi_i) cnt_q[CNT_W-1:HALF] <= wdata_i[CNT_W-1:HALF];
    end else if (inc_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && wr_hi_i) |=> cnt_q == $past(wdata_i));  // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !sw_wr) |=> $stable(cnt_q));  // R3

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !sw_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));  // R2

endmodule

// File: rtl/evt_ctr_csr.sv
module evt_ctr_csr
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned ADDR_W  = 13,
  parameter logic [31:0] VERSION = 32'h0000_0021
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic                          wide_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CNT_W-1:0]              wdata_i,
  output logic [CNT_W-1:0]              rdata_o,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_CNT-1:0]            wrap_i,
  output logic                          run_o,
  output logic [NUM_CNT-1:0]            en_o,
  output logic [NUM_CNT-1:0][7:0]       sel_o,
  output logic [NUM_CNT-1:0]            cnt_wr_lo_o,
  output logic [NUM_CNT-1:0]            cnt_wr_hi_o,
  output logic [CNT_W-1:0]              cnt_wdata_o,
  output logic                          irq_o
);

  localparam int unsigned HALF    = CNT_W / 2;
  localparam logic [31:0] CNT_END = CNT_BASE + 32'(8 * NUM_CNT);

  logic [31:0]              addr_ext;
  logic                     wr_en, rd_en;
  logic                     cnt_sel, cnt_hi;
  logic [31:2]              cnt_off;
  logic [NUM_CNT-1:0]       cnt_match;
  logic [NUM_CNT-1:0]       clr_bits;

  logic                     run_q;
  logic [NUM_CNT-1:0]       en_q, mask_q, st_q;
  logic [NUM_CNT-1:0][7:0]  sel_q;

  assign addr_ext = 32'(addr_i);
  assign wr_en    = req_i & we_i;
  assign rd_en    = req_i & ~we_i;
  assign cnt_sel  = (addr_ext >= CNT_BASE) && (addr_ext < CNT_END);
  assign cnt_off  = addr_ext[31:2] - CNT_BASE[31:2];
  assign cnt_hi   = cnt_off[2];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_dec
    assign cnt_match[n]   = cnt_sel && (cnt_off[31:3] == 29'(n));
    assign cnt_wr_lo_o[n] = wr_en & cnt_match[n] & (wide_i | ~cnt_hi);
    assign cnt_wr_hi_o[n] = wr_en & cnt_match[n] & (wide_i |  cnt_hi);
  end

  // a 32-bit write carries its word in both halves; the decode picks the half
  assign cnt_wdata_o = wide_i ? wdata_i : {wdata_i[HALF-1:0], wdata_i[HALF-1:0]};

  assign clr_bits = (wr_en && addr_ext == CLR_ADDR) ? wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      st_q   <= '0;
      sel_q  <= '0;
    end else begin
      st_q <= (st_q & ~clr_bits) | wrap_i;  // a wrap beats a clear
      if (wr_en) begin
        if (addr_ext == RUN_ADDR)  run_q  <= wdata_i[0];
        if (addr_ext == EN_ADDR)   en_q   <= wdata_i[NUM_CNT-1:0];
        if (addr_ext == MASK_ADDR) mask_q <= wdata_i[NUM_CNT-1:0];
        for (int n = 0; n < NUM_CNT; n++) begin
          if (addr_ext == SEL_BASE + 32'(4 * (n / 4)))
            sel_q[n] <= wdata_i[8*(n%4) +: 8];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (addr_ext == RUN_ADDR)  rdata_o[0]           = run_q;
      if (addr_ext == EN_ADDR)   rdata_o[NUM_CNT-1:0] = en_q;
      if (addr_ext == MASK_ADDR) rdata_o[NUM_CNT-1:0] = mask_q;
      if (addr_ext == STAT_ADDR) rdata_o[NUM_CNT-1:0] = st_q;
      if (addr_ext == VER_ADDR)  rdata_o[31:0]        = VERSION;
      for (int n = 0; n < NUM_CNT; n++) begin
        if (addr_ext == SEL_BASE + 32'(4 * (n / 4)))
          rdata_o[8*(n%4) +: 8] = sel_q[n];
        if (cnt_match[n]) begin
          if (wide_i)      rdata_o = cnt_i[n];
          else if (cnt_hi) rdata_o = {{HALF{1'b0}}, cnt_i[n][CNT_W-1:HALF]};
          else             rdata_o = {{HALF{1'b0}}, cnt_i[n][HALF-1:0]};
        end
      end
    end
  end

  assign run_o = run_q;
  assign en_o  = en_q;
  assign sel_o = sel_q;
  assign irq_o = |(st_q & ~mask_q);

  AST_STATUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_i) |=> ((st_q & $past(wrap_i)) == $past(wrap_i)));  // R5

  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|clr_bits) && !(|wrap_i)) |=> ((st_q & $past(clr_bits)) == '0));  // R8

  AST_RUN_OFF_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(|wrap_i));  // R3

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned ADDR_W  = 13,
  parameter logic [31:0] VERSION = 32'h0000_0021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              rx_req_i,
  input  logic              rx_dat_i,
  input  logic              tx_req_i,
  input  logic              tx_dat_i,
  input  logic              tick_i,
  output logic              irq_o
);

  ev_vec_t                      ev;
  logic                         run;
  logic [NUM_CNT-1:0]           en, hit, inc, wrap, wr_lo, wr_hi;
  logic [NUM_CNT-1:0][7:0]      sel;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0]             cnt_wdata;

  assign ev = {tick_i, tx_dat_i, tx_req_i, rx_dat_i, rx_req_i};

  evt_ctr_csr #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .VERSION(VERSION)
  ) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .wide_i     (wide_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .wrap_i     (wrap),
    .run_o      (run),
    .en_o       (en),
    .sel_o      (sel),
    .cnt_wr_lo_o(wr_lo),
    .cnt_wr_hi_o(wr_hi),
    .cnt_wdata_o(cnt_wdata),
    .irq_o      (irq_o)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evt_ctr_sel u_sel (
      .code_i(sel[g]),
      .ev_i  (ev),
      .hit_o (hit[g])
    );

    assign inc[g] = run & en[g] & hit[g];

    evt_ctr_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .wr_lo_i(wr_lo[g]),
      .wr_hi_i(wr_hi[g]),
      .wdata_i(cnt_wdata),
      .cnt_o  (cnt[g]),
      .wrap_o (wrap[g])
    );
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_lo | wr_hi));  // R6

endmodule

// File: tb/test_evt_ctr_bank.sv
module test_evt_ctr_bank;
  localparam int NC = 8;
  localparam logic [31:0] VER = 32'h0000_0021;
  localparam int A_MASK = 'h814, A_STAT = 'h818, A_CLR = 'h81c, A_RUN = 'h1c00;
  localparam int A_EN = 'h1c14, A_SEL0 = 'h1c18, A_SEL1 = 'h1c1c, A_VER = 'h1cf0, A_CNT = 'h1d00;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, wide = 0;
  logic [12:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic rx_req = 0, rx_dat = 0, tx_req = 0, tx_dat = 0, tick = 0, irq;
  int ev_mode = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  evt_ctr_bank #(.VERSION(VER)) i_evt_ctr_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_req_i(rx_req), .rx_dat_i(rx_dat), .tx_req_i(tx_req), .tx_dat_i(tx_dat),
    .tick_i(tick), .irq_o(irq)
  );

  // behavioural reference
  logic [63:0] m_cnt [NC];
  logic [7:0]  m_sel [NC];
  logic [NC-1:0] m_en, m_mask, m_st;
  logic m_run;

  function automatic bit m_hit(logic [7:0] c);
    case (c)
      8'h30: return rx_req;
      8'h31: return rx_dat;
      8'h34: return tx_req;
      8'h35: return tx_dat;
      8'h09: return tick;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] m_read(int ai, bit w);
    logic [63:0] r = '0;
    if (ai == A_MASK) r[NC-1:0] = m_mask;
    if (ai == A_STAT) r[NC-1:0] = m_st;
    if (ai == A_RUN)  r[0] = m_run;
    if (ai == A_EN)   r[NC-1:0] = m_en;
    if (ai == A_VER)  r[31:0] = VER;
    if (ai == A_SEL0 || ai == A_SEL1)
      for (int b = 0; b < 4; b++) r[8*b +: 8] = m_sel[(ai - A_SEL0) + b];
    if (ai >= A_CNT && ai < A_CNT + 8*NC) begin
      int n = (ai - A_CNT) / 8;
      if (w) r = m_cnt[n];
      else if (ai % 8 >= 4) r = {32'b0, m_cnt[n][63:32]};
      else r = {32'b0, m_cnt[n][31:0]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NC; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
      m_en = '0; m_mask = '1; m_st = '0; m_run = 0;
    end else begin : step
      logic [NC-1:0] wrap_v, clr_v;
      int ai;
      bit wr;
      bit inc_v [NC];
      wr = req && we;
      ai = int'(addr);
      wrap_v = '0;
      clr_v = '0;
      for (int n = 0; n < NC; n++) inc_v[n] = m_run && m_en[n] && m_hit(m_sel[n]);
      for (int n = 0; n < NC; n++) begin
        if (wr && ai >= A_CNT && ai < A_CNT + 8*NC && (ai - A_CNT) / 8 == n) begin
          if (wide) m_cnt[n] = wdata;
          else if (ai % 8 >= 4) m_cnt[n][63:32] = wdata[31:0];
          else m_cnt[n][31:0] = wdata[31:0];
        end else if (inc_v[n]) begin
          if (m_cnt[n] == '1) wrap_v[n] = 1;
          m_cnt[n] = m_cnt[n] + 64'd1;
        end
      end
      if (wr && ai == A_CLR) clr_v = wdata[NC-1:0];
      m_st = (m_st & ~clr_v) | wrap_v;
      if (wr) begin
        if (ai == A_RUN)  m_run = wdata[0];
        if (ai == A_EN)   m_en = wdata[NC-1:0];
        if (ai == A_MASK) m_mask = wdata[NC-1:0];
        if (ai == A_SEL0 || ai == A_SEL1)
          for (int b = 0; b < 4; b++) m_sel[(ai - A_SEL0) + b] = wdata[8*b +: 8];
      end
    end
  end

  task automatic chk(bit ok, string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h t=%0t", t, addr, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq === |(m_st & ~m_mask), "R7", {63'b0, irq}, {63'b0, |(m_st & ~m_mask)});
      if (req && !we) chk(rdata === m_read(int'(addr), wide), tag, rdata, m_read(int'(addr), wide));
    end
  end

  always @(posedge clk) begin
    #1;
    case (ev_mode)
      1: {tick, tx_dat, tx_req, rx_dat, rx_req} = 5'($urandom);
      2: {tick, tx_dat, tx_req, rx_dat, rx_req} = 5'h1f;
      default: {tick, tx_dat, tx_req, rx_dat, rx_req} = 5'h00;
    endcase
  end

  task automatic cyc(); @(posedge clk); #2; endtask

  task automatic wr32(int a, logic [31:0] d);
    req = 1; we = 1; wide = 0; addr = 13'(a); wdata = {32'b0, d};
    cyc(); req = 0; we = 0;
  endtask

  task automatic wr64(int a, logic [63:0] d);
    req = 1; we = 1; wide = 1; addr = 13'(a); wdata = d;
    cyc(); req = 0; we = 0; wide = 0;
  endtask

  task automatic rd(int a, bit w, string t);
    tag = t; req = 1; we = 0; wide = w; addr = 13'(a);
    cyc(); req = 0; wide = 0;
  endtask

  task automatic idle(int n); repeat (n) cyc(); endtask

  task automatic read_all(string t);
    for (int n = 0; n < NC; n++) rd(A_CNT + 8*n, 1, t);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc();
    // R1 reset state
    rd(A_MASK, 0, "R1"); rd(A_STAT, 0, "R1"); rd(A_RUN, 0, "R1");
    rd(A_EN, 0, "R1"); rd(A_SEL0, 0, "R1"); rd(A_SEL1, 0, "R1");
    read_all("R1");
    // R10 version
    rd(A_VER, 0, "R10"); wr32(A_VER, 32'hdead_beef); rd(A_VER, 0, "R10");
    // R4 select layout; counter 5 gets an unsupported code
    wr32(A_SEL0, 32'h3534_3130); wr32(A_SEL1, 32'h3009_7709);
    rd(A_SEL0, 0, "R4"); rd(A_SEL1, 0, "R4");
    // R3 enables set but run bit clear
    wr32(A_EN, 32'hff); ev_mode = 1; idle(20); read_all("R3");
    // R2 counting under random and all-high strobes
    wr32(A_RUN, 1); idle(30); read_all("R2");
    rd(A_CNT + 8*5, 1, "R9");
    ev_mode = 2; idle(5); read_all("R2");
    // R3 per-counter enable
    wr32(A_EN, 32'hbf); ev_mode = 1; idle(10); read_all("R3");
    // R6 write priority, R5 wrap, R7 mask, R8 clear
    ev_mode = 2;
    wr64(A_CNT + 32, 64'hffff_ffff_ffff_fffc);
    rd(A_CNT + 32, 0, "R6"); rd(A_CNT + 36, 0, "R6");
    idle(4); rd(A_STAT, 0, "R5");
    wr32(A_MASK, 32'hef); idle(2);
    wr32(A_CLR, 32'h0); rd(A_STAT, 0, "R8");
    wr32(A_CLR, 32'h10); rd(A_STAT, 0, "R8"); rd(A_CLR, 0, "R8");
    // wrap lands in the same cycle as the clear
    wr64(A_CNT + 32, 64'hffff_ffff_ffff_ffff);
    wr32(A_CLR, 32'h10); rd(A_STAT, 0, "R8");
    wr32(A_CLR, 32'h10); wr32(A_MASK, 32'hff); rd(A_STAT, 0, "R5");
    // R6 half-word access on counter 7
    ev_mode = 1;
    wr32(A_CNT + 56, 32'h1234_5678); wr32(A_CNT + 60, 32'h9abc_def0);
    rd(A_CNT + 56, 0, "R6"); rd(A_CNT + 60, 0, "R6"); rd(A_CNT + 56, 1, "R6");
    // R3 stop
    wr32(A_RUN, 0); idle(10); read_all("R3");
    ev_mode = 0;
    finish_run();
  end

endmodule